// File: doc/BRIEF.md
# Privileged-Mode Residency Watchdog

This block observes the stream of retired instructions and flags two kinds of trouble. The first is a run of privileged execution, in either the operating-system or the hypervisor level, that goes on too long without any return to application code. The second is a stall in which nothing retires for a long stretch of clock ticks. Each condition sets its own sticky symptom flag. Software-facing logic elsewhere reads the flags and releases them with a one-cycle clear pulse.

The run length counts only ordinary privileged work. Instructions that retire inside a system call, or while the OS is in its idle loop, leave the count where it is. Any cycle spent in user mode ends the run. Each privilege level has its own limit: 7000 instructions at reset for the hypervisor and 30000 for the OS. Normal runs vary from one workload to another, so both limits can be rewritten through a small write port. The stall limit is a parameter with a default of 65536 ticks.

Top module: `priv_residency_watchdog`

## Requirements
- R1: After a synchronous reset, both symptom flags read 0, the run length reads 0, the OS limit is 30000 and the hypervisor limit is 7000.
- R2: At an edge where `retire_i` is 1, the mode is privileged and both `syscall_i` and `idle_i` are 0, the run length increases by 1. Mode encoding: 00 user, 01 OS, 10 and 11 hypervisor.
- R3: At an edge with mode OS or hypervisor where no instruction retires, or where the retiring instruction has `syscall_i` or `idle_i` set, the run length does not change.
- R4: At any edge where the mode is user (00), the run length becomes 0, whether or not an instruction retires.
- R5: `hi_act_o` is set at the edge where a counted retire first brings the run length up to or past the limit of the current mode: the OS limit for 01, the hypervisor limit for 10 and 11. It fires at most once per excursion, and an excursion ends only at an edge in user mode.
- R6: Both flags stay set until an edge with `clear_i` high, which clears them. If a flag's set condition and `clear_i` fall on the same edge, the flag ends up set.
- R7: `stall_o` is set at the edge where the number of consecutive edges without a retire reaches STALL_TICKS (default 65536). Any retire restarts this count. The flag is raised only once per gap.
- R8: At an edge with `thr_we_i` high, `thr_val_i` becomes the OS limit if `thr_sel_i` is 0, or the hypervisor limit if it is 1. The new limit applies from the following edge onward.
- R9: The run length saturates at 2^CNT_W-1 (65535 by default) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One instruction retired this cycle |
| mode_i | input | 2 | Privilege level of the current instruction stream |
| syscall_i | input | 1 | The retiring instruction belongs to a system call |
| idle_i | input | 1 | The retiring instruction belongs to the OS idle loop |
| clear_i | input | 1 | Clears both symptom flags |
| thr_we_i | input | 1 | Limit write enable |
| thr_sel_i | input | 1 | Limit select: 0 OS, 1 hypervisor |
| thr_val_i | input | CNT_W | Limit value to write |
| hi_act_o | output | 1 | Sticky symptom: privileged run too long |
| stall_o | output | 1 | Sticky symptom: retirement stalled |
| run_len_o | output | CNT_W | Current privileged run length |

## Verification
The clear pulse and the set of a symptom can land on the same edge, and the block has to settle that race without losing the event. The bench lowers the hypervisor limit to 3, retires two counted instructions in mode 11, and then raises `clear_i` together with the third retire. The flag must read 1 after that edge. A clear pulse sent later on, during the same excursion, must drop the flag and keep it down.

// File: rtl/pmw_pkg.sv
package pmw_pkg;

    typedef enum logic [1:0] {
        PM_USER    = 2'b00,
        PM_OS      = 2'b01,
        PM_HYP     = 2'b10,
        PM_HYP_ALT = 2'b11
    } pm_mode_e;

    typedef struct packed {
        logic counted;
        logic leave;
        logic hyp;
    } pm_event_t;

    localparam int unsigned DEF_OS_LIMIT  = 30000;
    localparam int unsigned DEF_HYP_LIMIT = 7000;
    localparam int unsigned DEF_STALL     = 65536;

    localparam int unsigned LIM_OS  = 0;
    localparam int unsigned LIM_HYP = 1;

    function automatic pm_event_t pm_classify(
        input logic       retire,
        input logic [1:0] mode,
        input logic       sc,
        input logic       idle
    );
        pm_event_t ev;
        ev.leave   = (mode == PM_USER);
        ev.hyp     = mode[1];
        ev.counted = retire && !ev.leave && !sc && !idle;
        return ev;
    endfunction

endpackage

// File: rtl/pmw_limit_bank.sv
module pmw_limit_bank #(
    parameter int unsigned W       = 16,
    parameter int unsigned OS_RST  = 30000,
    parameter int unsigned HYP_RST = 7000
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we_i,
    input  logic         sel_i,
    input  logic [W-1:0] val_i,
    input  logic         hyp_i,
    output logic [W-1:0] limit_o
);
    localparam int unsigned N = 2;

    logic [W-1:0] lim_q [N];

    for (genvar g = 0; g < N; g++) begin : g_lim
        localparam logic [W-1:0] RST_V = (g == pmw_pkg::LIM_HYP) ? W'(HYP_RST) : W'(OS_RST);
        always_ff @(posedge clk) begin
            if (rst) begin
                lim_q[g] <= RST_V;
            end else if (we_i && (sel_i == 1'(g))) begin
                lim_q[g] <= val_i;
            end
        end
    end

    assign limit_o = hyp_i ? lim_q[pmw_pkg::LIM_HYP] : lim_q[pmw_pkg::LIM_OS];
endmodule

// File: rtl/pmw_run_ctr.sv
module pmw_run_ctr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         counted_i,
    input  logic         leave_i,
    input  logic [W-1:0] limit_i,
    output logic [W-1:0] run_o,
    output logic         hit_o
);
    localparam logic [W-1:0] MAXV = '1;

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_inc;
    logic         fired_q;

    always_comb begin
        cnt_inc = (cnt_q == MAXV) ? MAXV : cnt_q + 1'b1;
        hit_o   = counted_i && !leave_i && !fired_q && (cnt_inc >= limit_i);
    end

    always_ff @(posedge clk) begin
        if (rst || leave_i) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
        end else begin
            if (counted_i) begin
                cnt_q <= cnt_inc;
            end
            if (hit_o) begin
                fired_q <= 1'b1;
            end
        end
    end

    assign run_o = cnt_q;
endmodule

// File: rtl/pmw_gap_timer.sv
module pmw_gap_timer #(
    parameter int unsigned LIMIT = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic retire_i,
    output logic hit_o
);
    localparam int unsigned GW = $clog2(LIMIT + 1);
    localparam logic [GW-1:0] LAST = GW'(LIMIT - 1);
    localparam logic [GW-1:0] TOP  = GW'(LIMIT);

    logic [GW-1:0] gap_q;

    assign hit_o = !retire_i && (gap_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || retire_i) begin
            gap_q <= '0;
        end else if (gap_q != TOP) begin
            gap_q <= gap_q + 1'b1;
        end
    end
endmodule

// File: rtl/pmw_sticky.sv
module pmw_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
        end else if (set_i) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/priv_residency_watchdog.sv
module priv_residency_watchdog #(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned STALL_TICKS = pmw_pkg::DEF_STALL,
    parameter int unsigned OS_LIMIT    = pmw_pkg::DEF_OS_LIMIT,
    parameter int unsigned HYP_LIMIT   = pmw_pkg::DEF_HYP_LIMIT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             retire_i,
    input  logic [1:0]       mode_i,
    input  logic             syscall_i,
    input  logic             idle_i,
    input  logic             clear_i,
    input  logic             thr_we_i,
    input  logic             thr_sel_i,
    input  logic [CNT_W-1:0] thr_val_i,
    output logic             hi_act_o,
    output logic             stall_o,
    output logic [CNT_W-1:0] run_len_o
);
    import pmw_pkg::*;

    localparam int unsigned NFLAG = 2;

    pm_event_t        ev;
    logic [CNT_W-1:0] limit;
    logic             run_hit;
    logic             gap_hit;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_q;

    assign ev = pm_classify(retire_i, mode_i, syscall_i, idle_i);

    pmw_limit_bank #(
        .W(CNT_W), .OS_RST(OS_LIMIT), .HYP_RST(HYP_LIMIT)
    ) u_limits (
        .clk(clk), .rst(rst), .we_i(thr_we_i), .sel_i(thr_sel_i),
        .val_i(thr_val_i), .hyp_i(ev.hyp), .limit_o(limit)
    );

    pmw_run_ctr #(.W(CNT_W)) u_run (
        .clk(clk), .rst(rst), .counted_i(ev.counted), .leave_i(ev.leave),
        .limit_i(limit), .run_o(run_len_o), .hit_o(run_hit)
    );

    pmw_gap_timer #(.LIMIT(STALL_TICKS)) u_gap (
        .clk(clk), .rst(rst), .retire_i(retire_i), .hit_o(gap_hit)
    );

    assign flag_set = {gap_hit, run_hit};

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        pmw_sticky u_flag (
            .clk(clk), .rst(rst), .set_i(flag_set[g]), .clr_i(clear_i),
            .flag_o(flag_q[g])
        );
    end

    assign hi_act_o = flag_q[0];
    assign stall_o  = flag_q[1];
endmodule

// File: rtl/pmw_checker.sv
module pmw_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             retire_i,
    input logic [1:0]       mode_i,
    input logic             syscall_i,
    input logic             idle_i,
    input logic             clear_i,
    input logic             hi_act_o,
    input logic             stall_o,
    input logic [CNT_W-1:0] run_len_o
);
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic priv_count;
    assign priv_count = retire_i && (mode_i != 2'b00) && !syscall_i && !idle_i;

    // R4
    user_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00) |=> (run_len_o == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (priv_count && run_len_o != MAXV) |=> (run_len_o == $past(run_len_o) + 1'b1));

    // R3
    no_count_chk: assert property (@(posedge clk) disable iff (rst)
        ((mode_i != 2'b00) && !priv_count) |=> $stable(run_len_o));

    // R9
    run_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (priv_count && run_len_o == MAXV) |=> (run_len_o == MAXV));

    // R5
    hi_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hi_act_o) |-> $past(priv_count));

    // R6
    hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hi_act_o && !clear_i) |=> hi_act_o);

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stall_o && !clear_i) |=> stall_o);

    // R7
    stall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stall_o) |-> !$past(retire_i));
endmodule

bind priv_residency_watchdog pmw_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .retire_i(retire_i), .mode_i(mode_i),
    .syscall_i(syscall_i), .idle_i(idle_i), .clear_i(clear_i),
    .hi_act_o(hi_act_o), .stall_o(stall_o), .run_len_o(run_len_o)
);

// File: tb/priv_residency_watchdog_tb.sv
module priv_residency_watchdog_tb;
    localparam logic [1:0] M_USR = 2'b00, M_OS = 2'b01, M_HYP = 2'b10, M_HYP2 = 2'b11;

    typedef struct {
        string tag;
        int    run;
        bit    hi;
        bit    st;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        retire = 1'b0;
    logic [1:0]  mode = M_USR;
    logic        sc = 1'b0, idle = 1'b0, clr = 1'b0;
    logic        thr_we = 1'b0, thr_sel = 1'b0;
    logic [15:0] thr_val = '0;
    logic        hi_act, stall;
    logic [15:0] run_len;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    priv_residency_watchdog u_dut (
        .clk(clk), .rst(rst), .retire_i(retire), .mode_i(mode),
        .syscall_i(sc), .idle_i(idle), .clear_i(clr),
        .thr_we_i(thr_we), .thr_sel_i(thr_sel), .thr_val_i(thr_val),
        .hi_act_o(hi_act), .stall_o(stall), .run_len_o(run_len)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: compares queued expectations just after each edge
    always @(posedge clk) begin
        cycles++;
        #1;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (run_len !== 16'(e.run) || hi_act !== e.hi || stall !== e.st) begin
                errors++;
                $display("FAIL %s: got run=%0d hi=%0b st=%0b, expected run=%0d hi=%0b st=%0b",
                         e.tag, run_len, hi_act, stall, e.run, e.hi, e.st);
            end
        end
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got %0d cycles, expected completion", cycles);
            finish_run();
        end
    end

    task automatic cyc(input bit r, input logic [1:0] m, input bit s, input bit i, input bit c);
        @(negedge clk);
        retire = r; mode = m; sc = s; idle = i; clr = c; thr_we = 1'b0;
    endtask

    task automatic wr_limit(input bit sel, input logic [15:0] v);
        @(negedge clk);
        retire = 1'b0; mode = M_USR; sc = 1'b0; idle = 1'b0; clr = 1'b0;
        thr_we = 1'b1; thr_sel = sel; thr_val = v;
    endtask

    task automatic expect_now(input string tag, input int run, input bit hi, input bit st);
        exp_t e;
        e.tag = tag; e.run = run; e.hi = hi; e.st = st;
        q.push_back(e);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        expect_now("R1 reset state", 0, 0, 0);
        @(negedge clk);
        rst = 1'b0;
        cyc(0, M_USR, 0, 0, 0);
        expect_now("R1 after reset", 0, 0, 0);

        // R2 counting in hypervisor
        for (int k = 0; k < 5; k++) cyc(1, M_HYP, 0, 0, 0);
        expect_now("R2 five counted retires", 5, 0, 0);
        // R3 excluded instructions
        cyc(1, M_HYP, 1, 0, 0);
        expect_now("R3 syscall retire", 5, 0, 0);
        cyc(1, M_OS, 0, 1, 0);
        expect_now("R3 idle retire", 5, 0, 0);
        cyc(0, M_OS, 0, 0, 0);
        expect_now("R3 no retire", 5, 0, 0);
        // R4 user return
        cyc(1, M_USR, 0, 0, 0);
        expect_now("R4 user retire clears", 0, 0, 0);

        // R5 hypervisor limit from reset (R1: 7000)
        for (int k = 0; k < 6999; k++) cyc(1, M_HYP, 0, 0, 0);
        expect_now("R5 below hyp limit", 6999, 0, 0);
        cyc(1, M_HYP, 0, 0, 0);
        expect_now("R5 hyp limit reached", 7000, 1, 0);
        for (int k = 0; k < 10; k++) cyc(1, M_HYP, 0, 0, 0);
        expect_now("R6 flag held", 7010, 1, 0);
        cyc(0, M_HYP, 0, 0, 1);
        expect_now("R6 clear drops flag", 7010, 0, 0);
        cyc(1, M_HYP, 0, 0, 0);
        expect_now("R5 once per excursion", 7011, 0, 0);
        cyc(0, M_USR, 0, 0, 0);
        expect_now("R4 user idle clears", 0, 0, 0);

        // R8 lower hyp limit, R6 set beats clear, mode 11 is hypervisor
        wr_limit(1'b1, 16'd3);
        expect_now("R8 write cycle", 0, 0, 0);
        cyc(1, M_HYP2, 0, 0, 0);
        cyc(1, M_HYP2, 0, 0, 0);
        expect_now("R8 below new hyp limit", 2, 0, 0);
        cyc(1, M_HYP2, 0, 0, 1);
        expect_now("R6 set wins over clear", 3, 1, 0);

        // R5 OS limit from reset (R1: 30000) and R9 saturation
        cyc(0, M_USR, 0, 0, 1);
        expect_now("R6 clear in user", 0, 0, 0);
        for (int k = 0; k < 29999; k++) cyc(1, M_OS, 0, 0, 0);
        expect_now("R5 below OS limit", 29999, 0, 0);
        cyc(1, M_OS, 0, 0, 0);
        expect_now("R5 OS limit reached", 30000, 1, 0);
        for (int k = 0; k < 35535; k++) cyc(1, M_OS, 0, 0, 0);
        expect_now("R9 at maximum", 65535, 1, 0);
        cyc(1, M_OS, 0, 0, 0);
        expect_now("R9 saturates", 65535, 1, 0);

        // R8 lower OS limit
        wr_limit(1'b0, 16'd4);
        cyc(0, M_USR, 0, 0, 1);
        expect_now("R8 clear before OS test", 0, 0, 0);
        for (int k = 0; k < 3; k++) cyc(1, M_OS, 0, 0, 0);
        expect_now("R8 below new OS limit", 3, 0, 0);
        cyc(1, M_OS, 0, 0, 0);
        expect_now("R8 new OS limit reached", 4, 1, 0);

        // R7 stall detection
        cyc(1, M_USR, 0, 0, 1);
        expect_now("R7 start of gap", 0, 0, 0);
        for (int k = 0; k < 65535; k++) cyc(0, M_USR, 0, 0, 0);
        expect_now("R7 gap one short", 0, 0, 0);
        cyc(0, M_USR, 0, 0, 0);
        expect_now("R7 stall raised", 0, 0, 1);
        cyc(0, M_USR, 0, 0, 1);
        expect_now("R6 stall cleared", 0, 0, 0);
        for (int k = 0; k < 5; k++) cyc(0, M_USR, 0, 0, 0);
        expect_now("R7 once per gap", 0, 0, 0);

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule